// File: doc/BRIEF.md
# Stepwise Power Mode Request Controller

This block sits between a register write port and a power manager. Software writes a target operating mode. The block accepts the write only when the target sits next to the current mode on a fixed four-rung ladder. It then forwards the request and waits for the power manager to confirm it. The mode the power manager has confirmed is the one software must treat as current. The mode still being requested is never treated as current.

Only one request can be outstanding. A write that arrives while a request is still unconfirmed is dropped, and so is a write that skips a rung or names the present mode. A dropped write sets a sticky error flag, and software clears that flag by writing one. Each mode also selects a regulator state: the two power-down rungs ask for the low-current supply, and the two active rungs ask for full power. A set of peripheral permit outputs is held low for analog-facing peripherals (oscillator control, time-to-digital counter, ADC interface) whenever the low-current supply is in effect or is about to be.

The handshake state machine has two states. ST_IDLE means no request is outstanding. ST_WAIT_ACK means a request has been forwarded and is unconfirmed. The transition ACCEPT (ST_IDLE to ST_WAIT_ACK) fires on a legal write. The transition COMPLETE (ST_WAIT_ACK to ST_IDLE) fires on an acknowledge pulse. In every other case the state holds.

Top module: `pmode_ladder_ctrl`

## Requirements
- R1: After reset the confirmed mode and the forwarded mode are both 1 (full active), busy is 0, the error flag is 0 and all permits are 1.
- R2: Modes are coded in ladder order: 0 = power-down active, 1 = full active, 2 = low power, 3 = power-down low power. A write while idle whose mode differs from the confirmed mode by exactly one is accepted. In the next cycle the forwarded mode equals the written value and busy is 1.
- R3: Steps in both directions are legal, including steps to and from both ends of the ladder (0 and 3).
- R4: A write while busy is dropped. It sets the error flag, and the forwarded mode stays unchanged. This also holds when the write coincides with the acknowledge pulse.
- R5: A write while idle that skips a rung or repeats the confirmed mode is dropped and sets the error flag. The forwarded mode and the confirmed mode stay unchanged, and busy stays 0.
- R6: An acknowledge pulse while busy makes the confirmed mode equal to the forwarded mode and clears busy in the next cycle. An acknowledge pulse while idle has no effect.
- R7: The error flag stays set until a cycle with the clear input at 1. If a dropped write and a clear happen in the same cycle, the flag ends up set.
- R8: The low-supply request output is 1 exactly when the forwarded mode is 0 or 3.
- R9: Each restricted permit bit is 1 only when the confirmed mode is 1 or 2 and, while busy, the forwarded mode is also 1 or 2. Unrestricted bits are always 1. By default bits 0 to 2 are restricted and bit 3 is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Mode write strobe |
| req_mode | input | 2 | Written target mode |
| err_clr | input | 1 | Write-one clear of the error flag |
| pm_ack | input | 1 | Single-cycle acknowledge from the power manager |
| pm_req_mode | output | 2 | Mode forwarded to the power manager |
| pm_busy | output | 1 | A request is outstanding |
| low_supply_req | output | 1 | Request for the low-current regulator state |
| cur_mode | output | 2 | Confirmed (current) mode |
| err_flag | output | 1 | Sticky illegal-write flag |
| periph_permit | output | NUM_PERIPH | Per-peripheral enable permits |

## Verification
The ladder is walked up from 1 to 3, down to 0 and back, which shows that both step directions and both ends are accepted. Writes that skip a rung, repeat the current mode, arrive while busy or coincide with the acknowledge separate the reasons for dropping a write from a correct acceptance. Stray acknowledges while idle and same-cycle set and clear of the error flag cover the remaining edge cases. A pseudo-random stretch of writes, clears and acknowledges is then compared cycle by cycle against a behavioural model.

// File: rtl/pmode_pkg.sv
package pmode_pkg;

    typedef enum logic [1:0] {
        MODE_PDA  = 2'd0,
        MODE_ACT  = 2'd1,
        MODE_LP   = 2'd2,
        MODE_PDLP = 2'd3
    } pmode_t;

    typedef enum logic {
        ST_IDLE     = 1'b0,
        ST_WAIT_ACK = 1'b1
    } hs_state_t;

    // power-down rungs ask for the low-current regulator
    function automatic logic is_low_supply(pmode_t m);
        return (m == MODE_PDA) || (m == MODE_PDLP);
    endfunction

    // true when the two rungs are neighbours on the ladder
    function automatic logic is_adjacent(pmode_t a, pmode_t b);
        logic [2:0] ea;
        logic [2:0] eb;
        ea = {1'b0, a};
        eb = {1'b0, b};
        return (ea == eb + 3'd1) || (eb == ea + 3'd1);
    endfunction

endpackage

// File: rtl/mode_step_check.sv
module mode_step_check
    import pmode_pkg::*;
(
    input  logic   req_valid,
    input  pmode_t req_mode,
    input  pmode_t cur_mode,
    input  logic   busy,
    output logic   accept,
    output logic   reject
);
    logic legal_step;

    always_comb begin
        legal_step = is_adjacent(req_mode, cur_mode);
        accept     = req_valid && !busy && legal_step;
        reject     = req_valid && (busy || !legal_step);
    end

    always_comb begin
        AST_ACCEPT_REJECT_EXCL: assert (!(accept && reject)); // R5
    end
endmodule

// File: rtl/mode_hs_fsm.sv
module mode_hs_fsm
    import pmode_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   accept,
    input  pmode_t req_mode,
    input  logic   ack_pulse,
    output logic   busy,
    output pmode_t fwd_mode,
    output pmode_t conf_mode
);
    hs_state_t state_q, state_d;
    pmode_t    fwd_q, conf_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: ACCEPT and COMPLETE transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (accept)    state_d = ST_WAIT_ACK;
            ST_WAIT_ACK: if (ack_pulse) state_d = ST_IDLE;
        endcase
    end

    // mode registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_q  <= MODE_ACT;
            conf_q <= MODE_ACT;
        end else begin
            unique case (state_q)
                ST_IDLE:     if (accept)    fwd_q  <= req_mode;
                ST_WAIT_ACK: if (ack_pulse) conf_q <= fwd_q;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q == ST_WAIT_ACK);
        fwd_mode  = fwd_q;
        conf_mode = conf_q;
    end

    AST_BUSY_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(fwd_q)); // R4
    AST_ACK_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ack_pulse) |=> (!busy && conf_q == $past(fwd_q))); // R6
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> is_adjacent(fwd_q, conf_q)); // R2
    AST_IDLE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (fwd_q == conf_q)); // R6
endmodule

// File: rtl/mode_err_flag.sv
module mode_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_err,
    input  logic clr_err,
    output logic err
);
    logic err_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (set_err) err_q <= 1'b1;
        else if (clr_err) err_q <= 1'b0;
    end

    assign err = err_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !clr_err) |=> err_q); // R7
    AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_err |=> err_q); // R7
endmodule

// File: rtl/mode_permit_gate.sv
module mode_permit_gate
    import pmode_pkg::*;
#(
    parameter int NUM_PERIPH = 4,
    parameter logic [NUM_PERIPH-1:0] RESTRICT_MASK = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  pmode_t                conf_mode,
    input  pmode_t                fwd_mode,
    input  logic                  busy,
    output logic [NUM_PERIPH-1:0] permit
);
    logic full_power_ok;

    assign full_power_ok = !is_low_supply(conf_mode) && !(busy && is_low_supply(fwd_mode));

    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_permit
        if (RESTRICT_MASK[i]) begin : g_gated
            assign permit[i] = full_power_ok;
            AST_PERMIT_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
                is_low_supply(conf_mode) |-> !permit[i]); // R9
        end else begin : g_free
            assign permit[i] = 1'b1;
        end
    end
endmodule

// File: rtl/pmode_ladder_ctrl.sv
module pmode_ladder_ctrl
    import pmode_pkg::*;
#(
    parameter int NUM_PERIPH = 4,
    parameter logic [NUM_PERIPH-1:0] RESTRICT_MASK = 4'b0111
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [1:0]            req_mode,
    input  logic                  err_clr,
    input  logic                  pm_ack,
    output logic [1:0]            pm_req_mode,
    output logic                  pm_busy,
    output logic                  low_supply_req,
    output logic [1:0]            cur_mode,
    output logic                  err_flag,
    output logic [NUM_PERIPH-1:0] periph_permit
);
    logic   accept, reject, busy;
    pmode_t fwd_mode, conf_mode;

    mode_step_check u_check (
        .req_valid (req_valid),
        .req_mode  (pmode_t'(req_mode)),
        .cur_mode  (conf_mode),
        .busy      (busy),
        .accept    (accept),
        .reject    (reject)
    );

    mode_hs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_mode  (pmode_t'(req_mode)),
        .ack_pulse (pm_ack),
        .busy      (busy),
        .fwd_mode  (fwd_mode),
        .conf_mode (conf_mode)
    );

    mode_err_flag u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_err (reject),
        .clr_err (err_clr),
        .err     (err_flag)
    );

    mode_permit_gate #(
        .NUM_PERIPH    (NUM_PERIPH),
        .RESTRICT_MASK (RESTRICT_MASK)
    ) u_permit (
        .clk       (clk),
        .rst_n     (rst_n),
        .conf_mode (conf_mode),
        .fwd_mode  (fwd_mode),
        .busy      (busy),
        .permit    (periph_permit)
    );

    assign pm_req_mode    = fwd_mode;
    assign pm_busy        = busy;
    assign cur_mode       = conf_mode;
    assign low_supply_req = is_low_supply(fwd_mode);

    AST_REJECT_KEEPS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !pm_busy && reject) |=> (!pm_busy && $stable(cur_mode))); // R5
endmodule

// File: tb/tb_pmode_ladder_ctrl.sv
`timescale 1ns/100ps
module tb_pmode_ladder_ctrl;
    localparam int NP = 4;
    localparam logic [NP-1:0] RMASK = 4'b0111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_mode = 2'd0;
    logic err_clr = 1'b0;
    logic pm_ack = 1'b0;
    logic [1:0] pm_req_mode, cur_mode;
    logic pm_busy, low_supply_req, err_flag;
    logic [NP-1:0] periph_permit;

    always #2.5 clk = ~clk;

    pmode_ladder_ctrl #(.NUM_PERIPH(NP), .RESTRICT_MASK(RMASK)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .err_clr(err_clr), .pm_ack(pm_ack), .pm_req_mode(pm_req_mode),
        .pm_busy(pm_busy), .low_supply_req(low_supply_req), .cur_mode(cur_mode),
        .err_flag(err_flag), .periph_permit(periph_permit)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    bit compare_on = 0;

    // behavioural reference model
    int m_ack = 1, m_req = 1, m_busy = 0, m_err = 0;

    function automatic bit m_low(int m);
        return (m == 0) || (m == 3);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ack = 1; m_req = 1; m_busy = 0; m_err = 0;
        end else begin
            int nb;
            bit set_e;
            int diff;
            nb = m_busy;
            set_e = 0;
            if (m_busy != 0 && pm_ack) begin
                m_ack = m_req;
                nb = 0;
            end
            if (req_valid) begin
                diff = int'(req_mode) - m_ack;
                if (m_busy == 0 && (diff == 1 || diff == -1)) begin
                    m_req = int'(req_mode);
                    nb = 1;
                end else begin
                    set_e = 1;
                end
            end
            if (set_e) m_err = 1;
            else if (err_clr) m_err = 0;
            m_busy = nb;
        end
    end

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (compare_on && rst_n) begin
            int full;
            int exp_perm;
            full = (!m_low(m_ack) && !(m_busy != 0 && m_low(m_req))) ? 1 : 0;
            exp_perm = full ? 4'hF : int'(~RMASK) & 4'hF;
            check("R2/R3 forwarded mode", int'(pm_req_mode), m_req);
            check("R4 busy", int'(pm_busy), m_busy);
            check("R6 confirmed mode", int'(cur_mode), m_ack);
            check("R7 error flag", int'(err_flag), m_err);
            check("R8 low supply request", int'(low_supply_req), m_low(m_req) ? 1 : 0);
            check("R9 permits", int'(periph_permit), exp_perm);
        end
    end

    task automatic write_mode(int m);
        @(negedge clk);
        req_valid = 1'b1;
        req_mode = 2'(m);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic ack_after(int n);
        repeat (n) @(negedge clk);
        pm_ack = 1'b1;
        @(negedge clk);
        pm_ack = 1'b0;
    endtask

    task automatic step(int m);
        write_mode(m);
        ack_after(2);
    endtask

    task automatic clear_err();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset confirmed", int'(cur_mode), 1);
        check("R1 reset forwarded", int'(pm_req_mode), 1);
        check("R1 reset busy", int'(pm_busy), 0);
        check("R1 reset error", int'(err_flag), 0);
        check("R1 reset permits", int'(periph_permit), 15);
        compare_on = 1;

        // R2 R3: walk up to the top, down to the bottom, back
        step(2); step(3); step(2); step(1); step(0); step(1);
        check("R3 returned to full active", int'(cur_mode), 1);

        // R5 skip and same-mode writes
        write_mode(3);
        check("R5 skip dropped, error", int'(err_flag), 1);
        check("R5 skip leaves idle", int'(pm_busy), 0);
        clear_err();
        write_mode(1);
        check("R5 same mode dropped", int'(err_flag), 1);
        clear_err();
        check("R7 cleared", int'(err_flag), 0);

        // R4 write while busy, then write coinciding with acknowledge
        write_mode(2);
        write_mode(3);
        check("R4 busy write keeps forwarded", int'(pm_req_mode), 2);
        check("R4 busy write sets error", int'(err_flag), 1);
        @(negedge clk);
        pm_ack = 1'b1; req_valid = 1'b1; req_mode = 2'd3;
        @(negedge clk);
        pm_ack = 1'b0; req_valid = 1'b0;
        check("R4 write at ack dropped", int'(pm_busy), 0);
        check("R6 ack committed", int'(cur_mode), 2);

        // R7 set and clear same cycle: set wins
        @(negedge clk);
        err_clr = 1'b1; req_valid = 1'b1; req_mode = 2'd0;
        @(negedge clk);
        err_clr = 1'b0; req_valid = 1'b0;
        check("R7 set wins over clear", int'(err_flag), 1);
        clear_err();

        // R6 stray acknowledge while idle
        ack_after(1);
        check("R6 stray ack ignored", int'(cur_mode), 2);
        check("R6 stray ack busy", int'(pm_busy), 0);

        // pseudo-random stretch
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            req_valid = lfsr[0] & lfsr[3];
            req_mode = lfsr[5:4];
            pm_ack = lfsr[7] & lfsr[8];
            err_clr = lfsr[9] & lfsr[11] & lfsr[2];
        end
        @(negedge clk);
        req_valid = 1'b0; pm_ack = 1'b0; err_clr = 1'b0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule